// File: doc/BRIEF.md
# Dual-Pixel Video Timing Generator

This block produces a parallel camera-style video stream from a built-in test pattern. Every rising clock edge it can present two horizontally adjacent 8-bit pixels on two lanes, together with a frame-valid and a line-valid strobe. Each frame is a raster scan of a rectangular window, line by line, from the top-left pixel to the bottom-right one. Blanking separates the lines and the frames.

The window comes from four values: the first column, the column count, the first row and the row count. They are written together with a single write strobe. Each write is checked at once. A rejected write raises an error flag and leaves the stored window as it was. An accepted window is held pending and is loaded only at the next frame boundary, while frame-valid is low, so a frame in flight keeps its geometry. After reset the window is the full 1280 x 1024 field. Each pixel value is (column + row) mod 256, using absolute sensor coordinates, so a capture shows both the position and the order of the pixels.

Top module: `dual_pixel_vtg`

## Requirements
- R1: While reset is high, `fval`, `lval`, both pixel lanes and `cfg_err` are 0.
- R2: Each frame carries exactly the window's row count of line-valid pulses. Each pulse lasts the window's column count / 2 clocks (one pixel pair per clock), and the first pair of the first line is the window's top-left corner.
- R3: During line-valid, `pix_a` carries the even (left) pixel and `pix_b` the odd (right) pixel of each pair. A pixel at absolute column c and row r has value (c + r) mod 256, and the column rises by 2 each clock along the line.
- R4: Whenever `lval` is low, both pixel lanes are 0.
- R5: `fval` rises exactly FV_LEAD clocks before the first `lval` of a frame, and falls in the clock right after the last `lval` clock of the frame.
- R6: Between two lines of one frame, `lval` stays low for exactly LINE_GAP clocks while `fval` stays high.
- R7: Between two frames, `fval` stays low for exactly FRAME_GAP clocks.
- R8: A window write is rejected if any of these holds: the first column is not a multiple of 10; the column count is not a multiple of 10; the column count is 0; the first column plus the column count exceeds 1280; the row count is 0; the first row plus the row count exceeds 1024. A rejected write sets `cfg_err` to 1 in the clock after the write and leaves the stored window unchanged. An accepted write clears `cfg_err`.
- R9: A window accepted while `fval` is high does not alter the frame in progress. It applies from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all outputs change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the four window fields |
| cfg_col0 | input | 11 | First column of the window |
| cfg_ncols | input | 11 | Column count of the window |
| cfg_row0 | input | 11 | First row of the window |
| cfg_nrows | input | 11 | Row count of the window |
| cfg_err | output | 1 | 1 after a rejected write, 0 after an accepted one |
| fval | output | 1 | Frame-valid strobe |
| lval | output | 1 | Line-valid strobe |
| pix_a | output | 8 | Even (left) pixel of the current pair |
| pix_b | output | 8 | Odd (right) pixel of the current pair |

## Verification
The raster is captured with several windows. A small window at the origin confirms the basic line and pair counts. An offset window shows that the absolute column and row enter the pixel value. A window at the bottom-right corner exercises pixel wrap-around and the right-edge limit, and a half-width window shows that long lines are counted correctly. Writes that break each legality rule in turn are each followed by a full frame capture, which shows that a rejected write leaves the previous geometry in place. A write made at the start of a frame tells a boundary-timed update apart from an immediate one, because that frame must still show the old window and the next frame the new one.

// File: rtl/dpvtg_pkg.sv
package dpvtg_pkg;

    localparam int MAX_COLS = 1280;
    localparam int MAX_ROWS = 1024;
    localparam int COL_W    = $clog2(MAX_COLS + 1);
    localparam int ROW_W    = $clog2(MAX_ROWS + 1);
    localparam int PAIR_W   = COL_W - 1;

    localparam logic [COL_W-1:0] COL_STEP = COL_W'(10);

    typedef struct packed {
        logic [COL_W-1:0] col0;
        logic [COL_W-1:0] ncols;
        logic [ROW_W-1:0] row0;
        logic [ROW_W-1:0] nrows;
    } aoi_t;

    typedef enum logic [1:0] {
        ST_FGAP,
        ST_LEAD,
        ST_LINE,
        ST_LGAP
    } ras_state_e;

    localparam aoi_t AOI_FULL = '{
        col0:  '0,
        ncols: COL_W'(MAX_COLS),
        row0:  '0,
        nrows: ROW_W'(MAX_ROWS)
    };

    // Legality of a requested window.
    function automatic logic aoi_ok(aoi_t a);
        logic [COL_W:0] cend;
        logic [ROW_W:0] rend;
        cend = {1'b0, a.col0} + {1'b0, a.ncols};
        rend = {1'b0, a.row0} + {1'b0, a.nrows};
        return ((a.col0 % COL_STEP) == '0)
            && ((a.ncols % COL_STEP) == '0)
            && (a.ncols != '0)
            && (cend <= (COL_W+1)'(MAX_COLS))
            && (a.nrows != '0)
            && (rend <= (ROW_W+1)'(MAX_ROWS));
    endfunction

endpackage

// File: rtl/dpvtg_aoi_regs.sv
module dpvtg_aoi_regs
    import dpvtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  aoi_t wr_aoi,
    input  logic frame_load,
    output aoi_t act,
    output logic err
);

    aoi_t pend;
    logic legal;

    assign legal = aoi_ok(wr_aoi);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= AOI_FULL;
            act  <= AOI_FULL;
            err  <= 1'b0;
        end else begin
            if (wr_en) begin
                err <= !legal;
                if (legal) begin
                    pend <= wr_aoi;
                end
            end
            if (frame_load) begin
                act <= pend;
            end
        end
    end

    // R8: an illegal request never reaches the pending window
    a_r8_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !legal) |=> $stable(pend));

endmodule

// File: rtl/dpvtg_raster.sv
module dpvtg_raster
    import dpvtg_pkg::*;
#(
    parameter int FV_LEAD   = 8,
    parameter int LINE_GAP  = 16,
    parameter int FRAME_GAP = 64,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COL_W-1:0]  ncols,
    input  logic [ROW_W-1:0]  nrows,
    output logic              frame_load,
    output logic              fval,
    output logic              lval,
    output logic [PAIR_W-1:0] pair,
    output logic [ROW_W-1:0]  row
);

    localparam logic [CNT_W-1:0] FGAP_END = CNT_W'(FRAME_GAP - 1);
    localparam logic [CNT_W-1:0] LEAD_END = CNT_W'(FV_LEAD - 1);
    localparam logic [CNT_W-1:0] LGAP_END = CNT_W'(LINE_GAP - 1);

    ras_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [PAIR_W-1:0] last_pair;
    logic [ROW_W-1:0]  last_row;

    assign last_pair  = ncols[COL_W-1:1] - PAIR_W'(1);
    assign last_row   = nrows - ROW_W'(1);
    assign frame_load = (st == ST_FGAP) && (cnt == FGAP_END);
    assign fval       = (st != ST_FGAP);
    assign lval       = (st == ST_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_FGAP;
            cnt  <= '0;
            pair <= '0;
            row  <= '0;
        end else begin
            case (st)
                ST_FGAP: begin
                    if (cnt == FGAP_END) begin
                        st  <= ST_LEAD;
                        cnt <= '0;
                        row <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_LEAD: begin
                    if (cnt == LEAD_END) begin
                        st   <= ST_LINE;
                        cnt  <= '0;
                        pair <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_LINE: begin
                    if (pair == last_pair) begin
                        pair <= '0;
                        cnt  <= '0;
                        st   <= (row == last_row) ? ST_FGAP : ST_LGAP;
                    end else begin
                        pair <= pair + PAIR_W'(1);
                    end
                end
                default: begin
                    if (cnt == LGAP_END) begin
                        st  <= ST_LINE;
                        cnt <= '0;
                        row <= row + ROW_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // R2: the pair being sent lies inside the window width
    a_r2_pair_in_window: assert property (@(posedge clk) disable iff (rst)
        lval |-> ({pair, 1'b0} < ncols));

    // R2: the line being sent lies inside the window height
    a_r2_row_in_window: assert property (@(posedge clk) disable iff (rst)
        fval |-> (row < nrows));

    // R5: a frame never opens directly on an active line
    a_r5_lead_before_line: assert property (@(posedge clk) disable iff (rst)
        $rose(fval) |-> !lval);

endmodule

// File: rtl/dpvtg_pattern.sv
module dpvtg_pattern
    import dpvtg_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COL_W-1:0]  col0,
    input  logic [ROW_W-1:0]  row0,
    input  logic              lval,
    input  logic [PAIR_W-1:0] pair,
    input  logic [ROW_W-1:0]  row,
    output logic [PIX_W-1:0]  pix_a,
    output logic [PIX_W-1:0]  pix_b
);

    logic [COL_W-1:0] xpos;
    logic [ROW_W-1:0] ypos;
    logic [PIX_W-1:0] base;

    assign xpos  = col0 + {pair, 1'b0};
    assign ypos  = row0 + row;
    assign base  = PIX_W'(xpos) + PIX_W'(ypos);
    assign pix_a = lval ? base : '0;
    assign pix_b = lval ? (base + PIX_W'(1)) : '0;

    // R3: along a line the left pixel advances by two columns per clock
    a_r3_lane_advance: assert property (@(posedge clk) disable iff (rst)
        (lval && $past(lval)) |-> (pix_a == $past(pix_a) + PIX_W'(2)));

endmodule

// File: rtl/dual_pixel_vtg.sv
module dual_pixel_vtg
    import dpvtg_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int FV_LEAD   = 8,
    parameter int LINE_GAP  = 16,
    parameter int FRAME_GAP = 64,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [COL_W-1:0] cfg_col0,
    input  logic [COL_W-1:0] cfg_ncols,
    input  logic [ROW_W-1:0] cfg_row0,
    input  logic [ROW_W-1:0] cfg_nrows,
    output logic             cfg_err,
    output logic             fval,
    output logic             lval,
    output logic [PIX_W-1:0] pix_a,
    output logic [PIX_W-1:0] pix_b
);

    aoi_t              wr_aoi;
    aoi_t              act;
    logic              frame_load;
    logic [PAIR_W-1:0] pair;
    logic [ROW_W-1:0]  row;

    assign wr_aoi = '{col0: cfg_col0, ncols: cfg_ncols, row0: cfg_row0, nrows: cfg_nrows};

    dpvtg_aoi_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wr_aoi     (wr_aoi),
        .frame_load (frame_load),
        .act        (act),
        .err        (cfg_err)
    );

    dpvtg_raster #(
        .FV_LEAD   (FV_LEAD),
        .LINE_GAP  (LINE_GAP),
        .FRAME_GAP (FRAME_GAP),
        .CNT_W     (CNT_W)
    ) u_raster (
        .clk        (clk),
        .rst        (rst),
        .ncols      (act.ncols),
        .nrows      (act.nrows),
        .frame_load (frame_load),
        .fval       (fval),
        .lval       (lval),
        .pair       (pair),
        .row        (row)
    );

    dpvtg_pattern #(
        .PIX_W (PIX_W)
    ) u_pattern (
        .clk   (clk),
        .rst   (rst),
        .col0  (act.col0),
        .row0  (act.row0),
        .lval  (lval),
        .pair  (pair),
        .row   (row),
        .pix_a (pix_a),
        .pix_b (pix_b)
    );

    // R9: the window in use is frozen while a frame is in flight
    a_r9_window_frozen: assert property (@(posedge clk) disable iff (rst)
        (fval && $past(fval)) |-> $stable(act));

endmodule

// File: tb/dual_pixel_vtg_bench.sv
module dual_pixel_vtg_bench;
    import dpvtg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 8;
    localparam int FV_LEAD    = 5;
    localparam int LINE_GAP   = 7;
    localparam int FRAME_GAP  = 40;

    typedef struct packed {
        int sc;
        int w;
        int sr;
        int h;
        bit ok;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{0,    20,  0,    3, 1'b1},   // origin window
        '{10,   30,  5,    4, 1'b1},   // offset window
        '{15,   20,  0,    2, 1'b0},   // start not multiple of ten
        '{20,   25,  0,    2, 1'b0},   // width not multiple of ten
        '{1270, 10,  1020, 4, 1'b1},   // bottom-right corner
        '{1270, 20,  0,    2, 1'b0},   // past right edge
        '{0,    0,   0,    2, 1'b0},   // zero width
        '{100,  40,  1023, 2, 1'b0},   // past bottom edge
        '{250,  10,  7,    0, 1'b0},   // zero height
        '{640,  640, 100,  2, 1'b1}    // half-width lines
    };

    logic             clk;
    logic             rst;
    logic             cfg_we;
    logic [COL_W-1:0] cfg_col0;
    logic [COL_W-1:0] cfg_ncols;
    logic [ROW_W-1:0] cfg_row0;
    logic [ROW_W-1:0] cfg_nrows;
    logic             cfg_err;
    logic             fval;
    logic             lval;
    logic [PIX_W-1:0] pix_a;
    logic [PIX_W-1:0] pix_b;

    int   checks = 0;
    int   fails  = 0;
    vec_t cur;

    dual_pixel_vtg #(
        .PIX_W     (PIX_W),
        .FV_LEAD   (FV_LEAD),
        .LINE_GAP  (LINE_GAP),
        .FRAME_GAP (FRAME_GAP),
        .CNT_W     (16)
    ) u_dual_pixel_vtg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_col0  (cfg_col0),
        .cfg_ncols (cfg_ncols),
        .cfg_row0  (cfg_row0),
        .cfg_nrows (cfg_nrows),
        .cfg_err   (cfg_err),
        .fval      (fval),
        .lval      (lval),
        .pix_a     (pix_a),
        .pix_b     (pix_b)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one window write; the error flag is sampled one clock later.
    task automatic write_aoi(input vec_t v);
        cfg_col0  = COL_W'(v.sc);
        cfg_ncols = COL_W'(v.w);
        cfg_row0  = ROW_W'(v.sr);
        cfg_nrows = ROW_W'(v.h);
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
        check(cfg_err == !v.ok, "R8 cfg_err after write", int'(cfg_err), int'(!v.ok));
        if (v.ok) cur = v;
    endtask

    // Capture one whole frame, starting at (or waiting for) the rise of fval.
    task automatic capture(input vec_t exp, input bit do_wr, input vec_t nw);
        int lead = 0;
        int lines = 0;
        int pairs;
        int gap;
        int len_err = 0;
        int pix_err = 0;
        int gap_err = 0;
        int blank_err = 0;
        int tail_err = 0;
        int ea;
        int eb;
        while (!fval) @(negedge clk);
        if (do_wr) begin
            lead++;
            if (pix_a != 0 || pix_b != 0) blank_err++;
            write_aoi(nw);
        end
        while (fval && !lval) begin
            lead++;
            if (pix_a != 0 || pix_b != 0) blank_err++;
            @(negedge clk);
        end
        while (fval) begin
            pairs = 0;
            while (lval) begin
                ea = (exp.sc + 2*pairs + exp.sr + lines) % 256;
                eb = (exp.sc + 2*pairs + 1 + exp.sr + lines) % 256;
                if (int'(pix_a) != ea || int'(pix_b) != eb) begin
                    if (pix_err == 0)
                        $display("  line %0d pair %0d: a=%0d b=%0d want %0d %0d",
                                 lines, pairs, pix_a, pix_b, ea, eb);
                    pix_err++;
                end
                pairs++;
                @(negedge clk);
            end
            lines++;
            if (pairs != exp.w / 2) len_err++;
            gap = 0;
            while (fval && !lval) begin
                gap++;
                if (pix_a != 0 || pix_b != 0) blank_err++;
                @(negedge clk);
            end
            if (fval && gap != LINE_GAP) gap_err++;
            if (!fval && gap != 0) tail_err++;
        end
        check(lead == FV_LEAD, "R5 fval lead", lead, FV_LEAD);
        check(tail_err == 0, "R5 fval tail", tail_err, 0);
        check(lines == exp.h, "R2 line count", lines, exp.h);
        check(len_err == 0, "R2 pairs per line", len_err, 0);
        check(pix_err == 0, "R3 pixel values", pix_err, 0);
        check(blank_err == 0, "R4 lanes zero in blanking", blank_err, 0);
        check(gap_err == 0, "R6 line gap", gap_err, 0);
    endtask

    initial begin
        int fgap;
        vec_t nb;
        rst = 1'b1;
        cfg_we = 1'b0;
        cfg_col0 = '0;
        cfg_ncols = '0;
        cfg_row0 = '0;
        cfg_nrows = '0;
        cur = '{0, 1280, 0, 1024, 1'b1};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fval == 0 && lval == 0, "R1 strobes low in reset", int'({fval, lval}), 0);
        check(pix_a == 0 && pix_b == 0, "R1 lanes zero in reset", int'({pix_a, pix_b}), 0);
        check(cfg_err == 0, "R1 cfg_err low in reset", int'(cfg_err), 0);
        rst = 1'b0;

        // Table walk: write each vector, then capture the following frame.
        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                while (!fval) @(negedge clk);
            end
            write_aoi(VECS[i]);
            while (fval) @(negedge clk);
            capture(cur, 1'b0, cur);
        end

        // R9: a window written at frame start must not change that frame.
        nb = '{30, 10, 2, 2, 1'b1};
        capture(cur, 1'b1, nb);
        // R7: blanking between frames
        fgap = 0;
        while (!fval) begin
            fgap++;
            @(negedge clk);
        end
        check(fgap == FRAME_GAP, "R7 frame gap", fgap, FRAME_GAP);
        capture(nb, 1'b0, nb);   // R9: the new window applies now

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule